// File: doc/BRIEF.md
# Multi-Source Reset Controller with Sticky Domain

This block turns three reset sources into two reset domains for one device. The sources are a cold bus reset, a warm reset and an in-band link hot reset. The two domains are ordinary logic and the sticky error-status registers. A cold reset clears both domains. A warm reset, and a hot reset received as an endpoint, clear only the ordinary logic, so error history survives them. When the device is the link master, a hot reset is its own request, and the block ignores it.

Every output asserts at once and releases in step with the core clock. The ordinary-logic reset is held for a fixed stretch after the last source goes away. A pad-safe output stays high for the whole time that logic is held in reset, so that outputs can be tristated or driven to safe levels. The configuration straps are sampled once when a cold reset ends. One strap bit selects endpoint or root behaviour. A cause register in the sticky domain records which sources made up the most recent reset.

Top module: `rst_domain_ctrl`

## Requirements
- R1: While `cold_rst_n` is low, `logic_rst_n` and `sticky_rst_n` are low and `pad_safe` is high. They take these values without waiting for a clock edge.
- R2: After `cold_rst_n` rises, `sticky_rst_n` is still low following the first core clock rising edge. It is high following the second.
- R3: `cfg_straps` takes the value of `strap_i` once, just after cold reset is released. It then holds that value through strap input changes, warm resets and hot resets, until the next cold reset.
- R4: `cfg_root` equals the latched strap bit 0: 1 selects root (link master) behaviour and 0 selects endpoint behaviour.
- R5: A low `warm_rst_n` drives `logic_rst_n` low at once and leaves `sticky_rst_n` high.
- R6: In endpoint mode, a high `hot_rst_req` drives `logic_rst_n` low within four core cycles, after synchronization, and leaves `sticky_rst_n` high.
- R7: In root mode, `hot_rst_req` has no effect. `logic_rst_n` stays high and `rst_cause` is unchanged.
- R8: After the last active source is released, `logic_rst_n` stays low for at least STRETCH (default 16) core cycles. It rises within STRETCH+4 cycles.
- R9: `pad_safe` is high exactly while `logic_rst_n` is low.
- R10: `rst_cause` uses bit 0 for cold, bit 1 for warm and bit 2 for hot. A cold release sets it to 3'b001. Each later reset episode replaces it with the OR of the sources seen during that episode. An episode ends when `logic_rst_n` rises again. Only a cold reset clears these bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| cold_rst_n | input | 1 | Cold bus reset, active low, asynchronous |
| warm_rst_n | input | 1 | Warm reset, active low, asynchronous |
| hot_rst_req | input | 1 | Link hot reset indication, active high, asynchronous |
| strap_i | input | STRAP_W | Configuration strap pins; bit 0 selects root mode |
| logic_rst_n | output | 1 | Ordinary-logic reset, active low |
| sticky_rst_n | output | 1 | Sticky error-status reset, active low |
| pad_safe | output | 1 | High while outputs must be safe |
| cfg_straps | output | STRAP_W | Straps latched at cold release |
| cfg_root | output | 1 | Latched root-mode selection |
| rst_cause | output | 3 | Sources of the most recent reset |

## Verification
A warm reset and an endpoint hot reset can reach the cause logic in the same cycle. Both then fold into one reset episode. The bench provokes this in two ways. It drives both sources low and high on the same clock, and random iterations also overlap them. It then expects `rst_cause` to read 3'b110 in endpoint mode and 3'b010 in root mode. The same overlaps check that `sticky_rst_n` never drops and that the stretch is counted from the later of the two releases.

// File: rtl/rdc_pkg.sv
package rdc_pkg;
  localparam int CAUSE_W = 3;
  localparam int CB_COLD = 0;
  localparam int CB_WARM = 1;
  localparam int CB_HOT  = 2;

  typedef logic [CAUSE_W-1:0] cause_t;

  // Next value of the cause register: a cold release starts fresh,
  // a new episode replaces the record, an ongoing one accumulates.
  function automatic cause_t cause_next(cause_t cur, logic in_ep, logic cold_rel,
                                        logic warm_act, logic hot_act);
    cause_t fresh;
    fresh = '0;
    if (cold_rel) begin
      fresh[CB_COLD] = 1'b1;
      return fresh;
    end
    fresh[CB_WARM] = warm_act;
    fresh[CB_HOT]  = hot_act;
    if (warm_act || hot_act) return in_ep ? (cur | fresh) : fresh;
    return cur;
  endfunction
endpackage

// File: rtl/rdc_sync2.sv
module rdc_sync2 #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh <= '0;
    else         sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/rdc_stretch.sv
module rdc_stretch #(
  parameter int STRETCH = 16
) (
  input  logic clk,
  input  logic arst_n,
  input  logic hold,
  output logic rst_n
);
  localparam int CW = $clog2(STRETCH + 1);
  localparam logic [CW-1:0] LIM = CW'(STRETCH);

  logic [CW-1:0] cnt;
  logic          rst_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cnt   <= '0;
      rst_q <= 1'b0;
    end else if (hold) begin
      cnt   <= '0;
      rst_q <= 1'b0;
    end else if (cnt != LIM) begin
      cnt   <= cnt + 1'b1;
    end else begin
      rst_q <= 1'b1;
    end
  end

  assign rst_n = rst_q;
endmodule

// File: rtl/rdc_strap_latch.sv
module rdc_strap_latch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         cold_rst_n,
  input  logic         cold_sync_n,
  input  logic [W-1:0] strap_i,
  output logic [W-1:0] cfg,
  output logic         capture
);
  logic seen;

  assign capture = cold_sync_n && !seen;

  always_ff @(posedge clk or negedge cold_rst_n) begin
    if (!cold_rst_n) begin
      seen <= 1'b0;
      cfg  <= '0;
    end else if (capture) begin
      seen <= 1'b1;
      cfg  <= strap_i;
    end
  end
endmodule

// File: rtl/rst_domain_ctrl.sv
module rst_domain_ctrl
  import rdc_pkg::*;
#(
  parameter int STRAP_W     = 8,
  parameter int STRETCH     = 16,
  parameter int SYNC_STAGES = 2,
  parameter int ROOT_BIT    = 0
) (
  input  logic               clk,
  input  logic               cold_rst_n,
  input  logic               warm_rst_n,
  input  logic               hot_rst_req,
  input  logic [STRAP_W-1:0] strap_i,
  output logic               logic_rst_n,
  output logic               sticky_rst_n,
  output logic               pad_safe,
  output logic [STRAP_W-1:0] cfg_straps,
  output logic               cfg_root,
  output logic [2:0]         rst_cause
);
  // Named internal events
  logic   warm_arst_n;
  logic   cold_sync_n;
  logic   warm_sync_n;
  logic   hot_sync;
  logic   hot_eff;
  logic   warm_act;
  logic   src_active;
  logic   cold_rel;
  logic   in_ep;
  cause_t cause_q;

  assign warm_arst_n = cold_rst_n & warm_rst_n;

  rdc_sync2 #(.STAGES(SYNC_STAGES)) u_cold_sync (
    .clk(clk), .arst_n(cold_rst_n), .d(1'b1), .q(cold_sync_n));

  rdc_sync2 #(.STAGES(SYNC_STAGES)) u_warm_sync (
    .clk(clk), .arst_n(warm_arst_n), .d(1'b1), .q(warm_sync_n));

  rdc_sync2 #(.STAGES(SYNC_STAGES)) u_hot_sync (
    .clk(clk), .arst_n(cold_rst_n), .d(hot_rst_req), .q(hot_sync));

  rdc_strap_latch #(.W(STRAP_W)) u_straps (
    .clk(clk), .cold_rst_n(cold_rst_n), .cold_sync_n(cold_sync_n),
    .strap_i(strap_i), .cfg(cfg_straps), .capture(cold_rel));

  assign cfg_root   = cfg_straps[ROOT_BIT];
  assign hot_eff    = hot_sync && !cfg_root;
  assign warm_act   = !warm_sync_n;
  assign src_active = !cold_sync_n || warm_act || hot_eff;

  rdc_stretch #(.STRETCH(STRETCH)) u_stretch (
    .clk(clk), .arst_n(warm_arst_n), .hold(src_active), .rst_n(logic_rst_n));

  assign sticky_rst_n = cold_sync_n;
  assign pad_safe     = !logic_rst_n;

  // Cause record lives in the sticky domain
  always_ff @(posedge clk or negedge cold_rst_n) begin
    if (!cold_rst_n) begin
      cause_q <= '0;
      in_ep   <= 1'b0;
    end else begin
      cause_q <= cause_next(cause_q, in_ep, cold_rel, warm_act, hot_eff);
      if (warm_act || hot_eff) in_ep <= 1'b1;
      else if (logic_rst_n)    in_ep <= 1'b0;
    end
  end

  assign rst_cause = cause_q;
endmodule

// File: rtl/rdc_chk.sv
module rdc_chk #(
  parameter int STRAP_W = 8,
  parameter int STRETCH = 16
) (
  input logic               clk,
  input logic               cold_rst_n,
  input logic               warm_rst_n,
  input logic               logic_rst_n,
  input logic               sticky_rst_n,
  input logic               pad_safe,
  input logic [STRAP_W-1:0] cfg_straps,
  input logic               cfg_root,
  input logic [2:0]         rst_cause,
  input logic               src_active,
  input logic               cold_rel,
  input logic               hot_eff
);
  localparam int QW = $clog2(STRETCH + 2);
  localparam logic [QW-1:0] QLIM = QW'(STRETCH + 1);
  localparam logic [QW-1:0] QMIN = QW'(STRETCH);

  logic [QW-1:0] quiet;
  always_ff @(posedge clk or negedge cold_rst_n) begin
    if (!cold_rst_n)       quiet <= '0;
    else if (src_active)   quiet <= '0;
    else if (quiet != QLIM) quiet <= quiet + 1'b1;
  end

  // R5
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!cold_rst_n)
    sticky_rst_n |=> sticky_rst_n);

  // R9
  pad_warm_chk: assert property (@(posedge clk) disable iff (!cold_rst_n)
    !warm_rst_n |-> pad_safe);

  // R3
  strap_hold_chk: assert property (@(posedge clk) disable iff (!cold_rst_n)
    !cold_rel |=> $stable(cfg_straps));

  // R7
  root_ignore_chk: assert property (@(posedge clk) disable iff (!cold_rst_n)
    (cfg_root && logic_rst_n && warm_rst_n) |=> (logic_rst_n || !warm_rst_n));

  // R6
  hot_cause_chk: assert property (@(posedge clk) disable iff (!cold_rst_n)
    hot_eff |=> rst_cause[2]);

  // R10
  cold_cause_chk: assert property (@(posedge clk) disable iff (!cold_rst_n)
    cold_rel |=> (rst_cause == 3'b001));

  // R8
  stretch_min_chk: assert property (@(posedge clk) disable iff (!cold_rst_n)
    $rose(logic_rst_n) |-> (quiet >= QMIN));
endmodule

bind rst_domain_ctrl rdc_chk #(.STRAP_W(STRAP_W), .STRETCH(STRETCH)) u_chk (
  .clk(clk), .cold_rst_n(cold_rst_n), .warm_rst_n(warm_rst_n),
  .logic_rst_n(logic_rst_n), .sticky_rst_n(sticky_rst_n), .pad_safe(pad_safe),
  .cfg_straps(cfg_straps), .cfg_root(cfg_root), .rst_cause(rst_cause),
  .src_active(src_active), .cold_rel(cold_rel), .hot_eff(hot_eff));

// File: tb/sim_rst_domain_ctrl.sv
`timescale 1ns/1ps
module sim_rst_domain_ctrl;
  localparam int SW = 8;
  localparam int STRETCH = 16;

  logic clk = 1'b0;
  logic cold_rst_n, warm_rst_n, hot_rst_req;
  logic [SW-1:0] strap_i;
  logic logic_rst_n, sticky_rst_n, pad_safe, cfg_root;
  logic [SW-1:0] cfg_straps;
  logic [2:0] rst_cause;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  logic [SW-1:0] exp_straps;
  logic [2:0]    exp_cause;

  always #2.5 clk = ~clk;

  rst_domain_ctrl #(.STRAP_W(SW), .STRETCH(STRETCH)) u0 (
    .clk(clk), .cold_rst_n(cold_rst_n), .warm_rst_n(warm_rst_n),
    .hot_rst_req(hot_rst_req), .strap_i(strap_i), .logic_rst_n(logic_rst_n),
    .sticky_rst_n(sticky_rst_n), .pad_safe(pad_safe), .cfg_straps(cfg_straps),
    .cfg_root(cfg_root), .rst_cause(rst_cause));

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] episode_cause(logic w, logic h, logic root);
    return {h & ~root, w, 1'b0};
  endfunction

  task automatic wait_release(output int lows);
    lows = 0;
    while (!logic_rst_n && lows < 200) begin
      @(negedge clk);
      if (!logic_rst_n) lows++;
    end
  endtask

  task automatic check_stable_state(input string tag);
    chk(cfg_straps == exp_straps, {"R3 ", tag}, 32'(cfg_straps), 32'(exp_straps));
    chk(cfg_root == exp_straps[0], {"R4 ", tag}, 32'(cfg_root), 32'(exp_straps[0]));
    chk(rst_cause == exp_cause, {"R10 ", tag}, 32'(rst_cause), 32'(exp_cause));
    chk(pad_safe == !logic_rst_n, {"R9 ", tag}, 32'(pad_safe), 32'(!logic_rst_n));
  endtask

  task automatic do_cold(input logic [SW-1:0] s);
    int lows;
    @(negedge clk);
    cold_rst_n = 1'b0;
    strap_i = s;
    #0.5;
    chk(!logic_rst_n && !sticky_rst_n && pad_safe, "R1 cold async",
        {logic_rst_n, sticky_rst_n, pad_safe}, 32'b001);
    repeat (3) @(negedge clk);
    cold_rst_n = 1'b1;
    @(negedge clk);
    chk(sticky_rst_n == 1'b0, "R2 sticky after 1 edge", 32'(sticky_rst_n), 0);
    @(negedge clk);
    chk(sticky_rst_n == 1'b1, "R2 sticky after 2 edges", 32'(sticky_rst_n), 1);
    repeat (2) @(negedge clk);
    strap_i = ~s;
    exp_straps = s;
    exp_cause = 3'b001;
    wait_release(lows);
    check_stable_state("cold");
  endtask

  task automatic do_warm(input int len, input bit with_hot);
    int lows;
    @(negedge clk);
    warm_rst_n = 1'b0;
    hot_rst_req = with_hot;
    #0.5;
    chk(!logic_rst_n, "R5 warm async", 32'(logic_rst_n), 0);
    chk(pad_safe, "R9 pad during warm", 32'(pad_safe), 1);
    repeat (len) begin
      @(negedge clk);
      chk(sticky_rst_n, "R5 sticky kept", 32'(sticky_rst_n), 1);
    end
    strap_i = $urandom();
    warm_rst_n = 1'b1;
    hot_rst_req = 1'b0;
    wait_release(lows);
    chk(lows >= STRETCH && lows <= STRETCH + 4, "R8 stretch warm", lows, STRETCH);
    exp_cause = episode_cause(1'b1, with_hot, exp_straps[0]);
    check_stable_state("warm");
  endtask

  task automatic do_hot(input int len);
    int lows;
    bit root;
    root = exp_straps[0];
    @(negedge clk);
    hot_rst_req = 1'b1;
    if (root) begin
      repeat (len + 4) begin
        @(negedge clk);
        chk(logic_rst_n, "R7 root ignores hot", 32'(logic_rst_n), 1);
      end
      hot_rst_req = 1'b0;
      repeat (4) @(negedge clk);
      chk(logic_rst_n, "R7 root after hot", 32'(logic_rst_n), 1);
    end else begin
      repeat (len) begin
        @(negedge clk);
        chk(sticky_rst_n, "R6 sticky kept", 32'(sticky_rst_n), 1);
      end
      chk(!logic_rst_n, "R6 hot resets logic", 32'(logic_rst_n), 0);
      strap_i = $urandom();
      hot_rst_req = 1'b0;
      wait_release(lows);
      chk(lows >= STRETCH && lows <= STRETCH + 4, "R8 stretch hot", lows, STRETCH);
      exp_cause = episode_cause(1'b0, 1'b1, 1'b0);
    end
    check_stable_state("hot");
  endtask

  initial begin
    void'($urandom(32'h1d5e_ed07));
    cold_rst_n = 1'b0;
    warm_rst_n = 1'b1;
    hot_rst_req = 1'b0;
    strap_i = '0;
    repeat (3) @(negedge clk);
    chk(!logic_rst_n && !sticky_rst_n && pad_safe && rst_cause == 3'b000,
        "R1 reset state", {rst_cause, logic_rst_n, sticky_rst_n, pad_safe}, 32'b001);

    // Directed: endpoint
    do_cold(8'hA4);
    do_hot(4);
    do_warm(5, 1'b0);
    do_warm(6, 1'b1);          // simultaneous warm + hot -> 110
    do_hot(8);
    // Directed: root
    do_cold(8'h3B);
    do_hot(6);
    do_warm(4, 1'b1);          // hot masked -> 010
    do_hot(5);
    // Strap wiggle with no reset
    strap_i = 8'h00;
    repeat (5) @(negedge clk);
    check_stable_state("wiggle");

    // Random mix
    for (int i = 0; i < 24; i++) begin
      int op;
      op = $urandom_range(0, 3);
      case (op)
        0: do_cold(SW'($urandom()));
        1: do_warm($urandom_range(3, 10), 1'($urandom_range(0, 1)));
        2: do_hot($urandom_range(4, 10));
        default: begin
          strap_i = $urandom();
          repeat ($urandom_range(1, 6)) @(negedge clk);
          check_stable_state("rand wiggle");
        end
      endcase
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end
endmodule